// File: doc/BRIEF.md
# Three-Phase Dual-Reload One-Shot Timer Bank

This block holds one down-counting one-shot timer for each of the three motor phases (U, V, W). All phases share one start event. That event is taken from one of two trigger inputs, and a select input chooses which one. When an idle timer is started, it loads a reload value and raises its pulse output. It then counts down once on every cycle in which the count enable is high. When the count reaches zero, the pulse drops. In the same cycle the pulse first reads low, a one-cycle falling-edge strobe is raised. Downstream pattern logic uses this strobe as the moment to advance the phase output.

Each phase has two reload values, A and B. In single mode every run loads A. In triangular-carrier mode successive runs load A, then B, then A again. A single timer therefore marks two edges per carrier period. Any change of the mode input sends the alternation back to A. A start that would load zero produces no pulse and no strobe, but it still uses up its place in the alternation. A trigger that arrives while a pulse is active is ignored.

Top module: `phase_oneshot_bank`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and in the first cycle after it, every `pulse_o` and `fall_o` bit is 0. The mode history is set to single, so the alternation points at reload A.
- R2: A start is the selected trigger being high on a clock edge. A start on an idle phase whose chosen reload value N is nonzero makes `pulse_o` high from the next cycle. The pulse stays high for exactly N clock edges that have `cnt_en_i` high. While `cnt_en_i` is low the pulse holds and the count is frozen.
- R3: With `mode_i` = 0 (single), every run loads `reload_a_i`. With `mode_i` = 1 (triangular), accepted starts load A, B, A, B and so on, beginning with A.
- R4: `fall_o` of a phase is high for exactly one cycle: the first cycle in which `pulse_o` is low after a run has ended.
- R5: A start on a phase whose `pulse_o` is high is ignored. This includes the last cycle of the pulse. The run length is not changed and the alternation does not advance.
- R6: A start on an idle phase whose chosen reload value is 0 produces no pulse and no strobe. In triangular mode the alternation still advances to the other register.
- R7: In a cycle where `mode_i` differs from its value in the previous cycle, the alternation returns to A. A start in that same cycle loads A.
- R8: `trig_sel_i` = 0 selects `trig_a_i` and `trig_sel_i` = 1 selects `trig_b_i`. The unselected trigger has no effect.
- R9: Each phase p uses its own reload fields, bits [p*16 +: 16] of `reload_a_i` and `reload_b_i`. Phase 0 is U, phase 1 is V and phase 2 is W. The phases run independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en_i | input | 1 | Count enable; the counters decrement only in cycles where it is high |
| trig_a_i | input | 1 | Trigger source A |
| trig_b_i | input | 1 | Trigger source B |
| trig_sel_i | input | 1 | Trigger select: 0 = A, 1 = B |
| mode_i | input | 1 | Run mode: 0 = single reload, 1 = triangular alternation |
| reload_a_i | input | 48 | First reload value for each phase, 16 bits per phase |
| reload_b_i | input | 48 | Second reload value for each phase, 16 bits per phase |
| pulse_o | output | 3 | One-shot pulse, one bit per phase |
| fall_o | output | 3 | One-cycle falling-edge strobe, one bit per phase |

## Verification
The directed patterns are:
- Single-mode starts with different reloads per phase, which tell the phases apart and show that run length follows the reload value.
- Triangular starts with unequal A and B values, which show the order of the alternation. A zero-loaded run placed among them shows that the alternation still advances.
- A retrigger on the final pulse cycle, which separates "ignored while busy" from "restart at the end".
- Pulses of the unselected trigger, a mode flip on the same edge as a start, and gaps in the count enable, which separate selection, the alternation reset and frozen counting.

Random cycles then mix sparse triggers, small reload values that are often zero, and an enable that drops often. The outputs of every phase are compared against the expected values in every cycle.

// File: rtl/phot_pkg.sv
package phot_pkg;
  typedef enum logic {TRIG_A = 1'b0, TRIG_B = 1'b1} trig_src_e;
  typedef enum logic {RUN_SINGLE = 1'b0, RUN_TRI = 1'b1} run_mode_e;
endpackage

// File: rtl/phot_trig_sel.sv
module phot_trig_sel
  import phot_pkg::*;
(
  input  logic      trig_a_i,
  input  logic      trig_b_i,
  input  trig_src_e src_i,
  output logic      start_o
);
  always_comb begin
    unique case (src_i)
      TRIG_A:  start_o = trig_a_i;
      TRIG_B:  start_o = trig_b_i;
      default: start_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/phot_reload_ptr.sv
module phot_reload_ptr
  import phot_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  run_mode_e     mode_i,
  input  logic          mode_chg_i,
  input  logic          start_i,
  input  logic          idle_i,
  input  logic [CW-1:0] reload_a_i,
  input  logic [CW-1:0] reload_b_i,
  output logic [CW-1:0] load_val_o
);
  logic ptr_q;
  logic ptr_eff;
  logic accept;

  // a mode change sends the alternation back to A for this cycle onward
  assign ptr_eff    = mode_chg_i ? 1'b0 : ptr_q;
  assign accept     = start_i & idle_i;
  assign load_val_o = ptr_eff ? reload_b_i : reload_a_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= 1'b0;
    end else if (accept) begin
      ptr_q <= (mode_i == RUN_TRI) ? ~ptr_eff : 1'b0;
    end else begin
      ptr_q <= ptr_eff;
    end
  end
endmodule

// File: rtl/phot_down_counter.sv
module phot_down_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en_i,
  input  logic          start_i,
  input  logic [CW-1:0] load_val_i,
  output logic          idle_o,
  output logic          pulse_o,
  output logic          fall_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          pulse_q;
  logic          fall_q;

  assign idle_o  = ~pulse_q;
  assign pulse_o = pulse_q;
  assign fall_o  = fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      fall_q <= 1'b0;
      if (pulse_q) begin
        if (cnt_en_i) begin
          cnt_q <= cnt_q - ONE;
          if (cnt_q == ONE) begin
            pulse_q <= 1'b0;
            fall_q  <= 1'b1;
          end
        end
      end else if (start_i && (load_val_i != '0)) begin
        cnt_q   <= load_val_i;
        pulse_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/phase_oneshot_bank.sv
module phase_oneshot_bank
  import phot_pkg::*;
#(
  parameter int NPH = 3,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en_i,
  input  logic              trig_a_i,
  input  logic              trig_b_i,
  input  logic              trig_sel_i,
  input  logic              mode_i,
  input  logic [NPH*CW-1:0] reload_a_i,
  input  logic [NPH*CW-1:0] reload_b_i,
  output logic [NPH-1:0]    pulse_o,
  output logic [NPH-1:0]    fall_o
);
  localparam int VW = NPH * CW;

  run_mode_e         mode_cur;
  run_mode_e         mode_q;
  logic              mode_chg;
  logic              start_w;
  logic [VW-1:0]     load_val_w;
  logic [NPH-1:0]    idle_w;

  assign mode_cur = run_mode_e'(mode_i);
  assign mode_chg = (mode_cur != mode_q);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= RUN_SINGLE;
    else     mode_q <= mode_cur;
  end

  phot_trig_sel u_tsel (
    .trig_a_i (trig_a_i),
    .trig_b_i (trig_b_i),
    .src_i    (trig_src_e'(trig_sel_i)),
    .start_o  (start_w)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    phot_reload_ptr #(.CW(CW)) u_ptr (
      .clk        (clk),
      .rst        (rst),
      .mode_i     (mode_cur),
      .mode_chg_i (mode_chg),
      .start_i    (start_w),
      .idle_i     (idle_w[p]),
      .reload_a_i (reload_a_i[p*CW +: CW]),
      .reload_b_i (reload_b_i[p*CW +: CW]),
      .load_val_o (load_val_w[p*CW +: CW])
    );

    phot_down_counter #(.CW(CW)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .cnt_en_i   (cnt_en_i),
      .start_i    (start_w),
      .load_val_i (load_val_w[p*CW +: CW]),
      .idle_o     (idle_w[p]),
      .pulse_o    (pulse_o[p]),
      .fall_o     (fall_o[p])
    );
  end
endmodule

// File: rtl/phot_checker.sv
module phot_checker #(
  parameter int NPH = 3,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en_i,
  input logic              mode_i,
  input logic              start_w,
  input logic [NPH*CW-1:0] reload_a_i,
  input logic [NPH*CW-1:0] load_val_w,
  input logic [NPH-1:0]    pulse_o,
  input logic [NPH-1:0]    fall_o
);
  for (genvar p = 0; p < NPH; p++) begin : g_chk
    a_r2_start_raises: assert property (@(posedge clk) disable iff (rst)
      (!pulse_o[p] && start_w && (load_val_w[p*CW +: CW] != '0)) |=> pulse_o[p]);

    a_r6_zero_quiet: assert property (@(posedge clk) disable iff (rst)
      (!pulse_o[p] && start_w && (load_val_w[p*CW +: CW] == '0)) |=> (!pulse_o[p] && !fall_o[p]));

    a_r2_freeze: assert property (@(posedge clk) disable iff (rst)
      (pulse_o[p] && !cnt_en_i) |=> (pulse_o[p] && !fall_o[p]));

    a_r4_strobe_after_fall: assert property (@(posedge clk) disable iff (rst)
      fall_o[p] |-> (!pulse_o[p] && $past(pulse_o[p])));

    a_r4_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
      fall_o[p] |=> !fall_o[p]);

    a_r5_rise_needs_start: assert property (@(posedge clk) disable iff (rst)
      $rose(pulse_o[p]) |-> $past(start_w));

    a_r3_single_uses_a: assert property (@(posedge clk) disable iff (rst)
      (!mode_i && !$past(mode_i)) |-> (load_val_w[p*CW +: CW] == reload_a_i[p*CW +: CW]));
  end
endmodule

bind phase_oneshot_bank phot_checker #(.NPH(NPH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cnt_en_i   (cnt_en_i),
  .mode_i     (mode_i),
  .start_w    (start_w),
  .reload_a_i (reload_a_i),
  .load_val_w (load_val_w),
  .pulse_o    (pulse_o),
  .fall_o     (fall_o)
);

// File: tb/phase_oneshot_bank_test.sv
`timescale 1ns/1ps
module phase_oneshot_bank_test;
  localparam int NPH = 3;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0, trig_a = 1'b0, trig_b = 1'b0, tsel = 1'b0, mode = 1'b0;
  logic [NPH-1:0][CW-1:0] ra, rb;
  logic [NPH-1:0] pulse, fall;

  always #5 clk = ~clk;

  phase_oneshot_bank #(.NPH(NPH), .CW(CW)) uut (
    .clk(clk), .rst(rst), .cnt_en_i(cnt_en), .trig_a_i(trig_a), .trig_b_i(trig_b),
    .trig_sel_i(tsel), .mode_i(mode), .reload_a_i(ra), .reload_b_i(rb),
    .pulse_o(pulse), .fall_o(fall)
  );

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // expected state, derived from the requirements
  logic [CW-1:0] e_cnt [NPH];
  logic          e_pulse [NPH];
  logic          e_fall [NPH];
  logic          e_ptr [NPH];
  logic          e_modeq;
  string         e_tag [NPH];

  task automatic model_step();
    logic st, chg, eff;
    logic [CW-1:0] v;
    st  = tsel ? trig_b : trig_a;                      // R8
    chg = (mode != e_modeq);                           // R7
    for (int p = 0; p < NPH; p++) begin
      if (rst) begin
        e_cnt[p] = '0; e_pulse[p] = 0; e_fall[p] = 0; e_ptr[p] = 0; e_tag[p] = "R1";
        continue;
      end
      eff = chg ? 1'b0 : e_ptr[p];
      v   = eff ? rb[p] : ra[p];                       // R3, R9
      e_fall[p] = 0;
      e_tag[p]  = chg ? "R7" : (mode ? "R3" : "R2");
      if (((tsel ? trig_a : trig_b) == 1'b1) && !st) e_tag[p] = "R8";
      if (e_pulse[p]) begin
        if (st) e_tag[p] = "R5";
        if (cnt_en) begin
          if (e_cnt[p] == 1) begin
            e_pulse[p] = 0; e_fall[p] = 1; e_tag[p] = "R4";
          end
          e_cnt[p] = e_cnt[p] - 1;
        end
        e_ptr[p] = eff;
      end else if (st) begin
        if (v != 0) begin
          e_cnt[p] = v; e_pulse[p] = 1;
        end else e_tag[p] = "R6";
        e_ptr[p] = mode ? ~eff : 1'b0;
      end else e_ptr[p] = eff;
    end
    e_modeq = rst ? 1'b0 : mode;
  endtask

  task automatic compare();
    for (int p = 0; p < NPH; p++) begin
      vectors++;
      if (pulse[p] !== e_pulse[p] || fall[p] !== e_fall[p]) begin
        miscompares++;
        $display("FAIL %s phase %0d: pulse/fall actual %b%b expected %b%b at %0t",
                 e_tag[p], p, pulse[p], fall[p], e_pulse[p], e_fall[p], $time);
      end
    end
  endtask

  // inputs are set at a falling edge; one call covers one rising edge
  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) begin
      model_step();
      @(negedge clk);
      compare();
      trig_a = 0; trig_b = 0;
    end
  endtask

  task automatic fire(bit use_b);
    if (use_b) trig_b = 1; else trig_a = 1;
    cyc();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    ra = '0; rb = '0;
    @(negedge clk);
    cyc(3);                                            // R1 reset state
    rst = 0; cnt_en = 1;
    cyc(2);                                            // R1 first cycles after reset
    // R2/R9: single mode, distinct per-phase lengths
    ra[0] = 3; ra[1] = 4; ra[2] = 5; rb[0] = 9; rb[1] = 9; rb[2] = 9;
    fire(0); cyc(7);
    // R2: enable gaps freeze the count
    fire(0); cnt_en = 0; cyc(3); cnt_en = 1; cyc(6);
    // R5: retrigger on the final pulse cycle of phase 0 (length 3)
    fire(0); cyc(2); trig_a = 1; cyc(); cyc(6);
    // R8: unselected trigger has no effect
    tsel = 1; trig_a = 1; cyc(); cyc(3); tsel = 0;
    // R3: triangular alternation, unequal A and B
    mode = 1; cyc();
    ra = '{16'd2, 16'd2, 16'd2}; rb = '{16'd6, 16'd6, 16'd6};
    for (int r = 0; r < 4; r++) begin fire(0); cyc(8); end
    // R6: zero value inside the alternation still advances it
    ra[1] = 0; fire(0); cyc(3); fire(0); cyc(8); ra[1] = 2;
    // R7: mode flip on the same edge as a start loads A
    fire(0); cyc(8);
    mode = 0; fire(0); cyc(4);
    mode = 1; fire(0); cyc(4);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      cnt_en = ($urandom_range(3) != 0);
      trig_a = ($urandom_range(5) == 0);
      trig_b = ($urandom_range(5) == 0);
      if ($urandom_range(40) == 0) tsel = ~tsel;
      if ($urandom_range(60) == 0) mode = ~mode;
      if ($urandom_range(7) == 0)
        for (int p = 0; p < NPH; p++) begin
          ra[p] = ($urandom_range(3) == 0) ? 16'd0 : 16'($urandom_range(1, 7));
          rb[p] = ($urandom_range(3) == 0) ? 16'd0 : 16'($urandom_range(1, 7));
        end
      if ($urandom_range(500) == 0) rst = 1; else rst = 0;
      model_step();
      @(negedge clk);
      compare();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule